// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Read Cache

This block is a direct-mapped read cache that sits between a load port and memory. It picks its set from the low bits of the virtual address, and those bits lie entirely inside the page offset. The tag and data arrays can therefore be read while a separate translator is still turning the virtual page into a physical page number. The stored tag is compared with that physical page number only after both the array read and the translation have finished. A hit returns the addressed 32-bit word. A miss fetches the whole line from memory at its physical address, installs it, and then returns the word.

The default geometry is 256 lines of 16 bytes with a 4 KiB page. This makes the 8 set bits plus the 4 byte-in-line bits exactly the 12 page-offset bits. The 20-bit physical page number is itself the stored tag. Any geometry in which set bits plus line-offset bits differ from the page-offset width is rejected when the design is elaborated.

A caller presents one request at a time while `req_ready` is high. The translator's answer comes on `xlat_valid`/`xlat_ppn` in a later cycle, which may be delayed by any number of cycles. Memory answers a single line request with four word beats in ascending address order, and a beat is any cycle with `mem_rvalid` high.

Top module: `vipt_cache`

## Requirements
- R1: Synchronous reset marks every line invalid, drives `resp_valid` and `mem_req_valid` low and `req_ready` high; the first access to any set after reset is a miss.
- R2: The set is `req_vaddr[11:4]` and the word within the line is `req_vaddr[3:2]`; virtual address bits 31..12 have no effect on which line or word is used.
- R3: An access hits only when the selected line is valid and its stored tag equals `xlat_ppn`; otherwise it misses and fetches the line.
- R4: On a hit, `resp_valid` is high for exactly one cycle, in the cycle after the one in which `xlat_valid` was sampled high, with the addressed word on `resp_data`.
- R5: While a request waits for translation, neither a response nor a memory request is produced, however many cycles the translation takes.
- R6: On a miss, `mem_req_valid` pulses for one cycle, in the cycle after translation, with `mem_req_addr` = {physical page number, set, 4'b0000}.
- R7: Refill beats are taken in word order 0..3 on cycles with `mem_rvalid` high, and gaps are allowed. One cycle after the fourth beat, the requested word is returned and the line becomes valid, so later accesses to any of its four words hit.
- R8: `req_ready` is low from acceptance until the response; a `req_valid` presented while it is low is ignored and leaves the pending access unchanged.
- R9: `xlat_valid` asserted while no request is pending is ignored: it produces no response, no memory request and no change to the stored lines.
- R10: A miss replaces the line in its set, so a later access with the previous physical page number to that set misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present |
| req_vaddr | input | 32 | Virtual byte address of the load |
| req_ready | output | 1 | Cache idle and able to take a request |
| xlat_valid | input | 1 | Translator result valid this cycle |
| xlat_ppn | input | 20 | Physical page number of the pending request |
| mem_req_valid | output | 1 | One-cycle line fetch request |
| mem_req_addr | output | 32 | Physical byte address of the line to fetch |
| mem_rvalid | input | 1 | Refill beat present |
| mem_rdata | input | 32 | Refill beat data |
| resp_valid | output | 1 | Load data valid (one cycle) |
| resp_data | output | 32 | Load data |

## Verification
The bench aims at the cases where a virtually indexed design most easily goes wrong. The first is virtual addresses that differ only above the page offset: a design that indexed with those bits would miss or return another line. The second is two physical pages that map to the same set: a design that compared a virtual tag, or skipped the comparison, would return stale data with no fetch. The bench also holds translation back for several cycles and raises `xlat_valid` while idle. A design that compared too early, or treated a late answer as fresh, would respond with a wrong word or issue a stray fetch. Refill beats arrive with a gap, and requests are driven while the cache is busy. Here a design that miscounted beats would return a misplaced word, and one that accepted a new request while busy would lose the pending one.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    localparam int ADDR_W  = 32;
    localparam int WORD_W  = 32;
    localparam int PAGE_W  = 12;          // page offset width
    localparam int IDX_W   = 8;           // set bits
    localparam int OFS_W   = 4;           // byte-in-line bits
    localparam int BYTE_W  = $clog2(WORD_W / 8);
    localparam int WSEL_W  = OFS_W - BYTE_W;
    localparam int WORDS   = 1 << WSEL_W;
    localparam int LINES   = 1 << IDX_W;
    localparam int TAG_W   = ADDR_W - PAGE_W;
    localparam int LINE_W  = WORDS * WORD_W;
    localparam int BEAT_W  = (WSEL_W > 0) ? WSEL_W : 1;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [WSEL_W-1:0] wsel_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [BEAT_W-1:0] beat_t;

    typedef struct packed {
        idx_t  idx;
        wsel_t wsel;
    } slot_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_REFILL
    } state_e;

    function automatic slot_t va_slot(input addr_t va);
        slot_t s;
        s.idx  = va[PAGE_W-1:OFS_W];
        s.wsel = va[OFS_W-1:BYTE_W];
        return s;
    endfunction

    function automatic word_t line_word(input line_t l, input wsel_t sel);
        return l[sel*WORD_W +: WORD_W];
    endfunction

    function automatic addr_t line_paddr(input tag_t ppn, input idx_t idx);
        return {ppn, idx, {OFS_W{1'b0}}};
    endfunction

endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store
    import vipt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rd_en,
    input  idx_t rd_idx,
    output logic rd_valid,
    output tag_t rd_tag,
    input  logic wr_en,
    input  idx_t wr_idx,
    input  tag_t wr_tag
);

    logic [LINES-1:0] valid_q;
    tag_t             tags_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tags_q[wr_idx] <= wr_tag;
        end
    end

    // registered read, overlapped with translation
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_tag   <= '0;
        end else if (rd_en) begin
            rd_valid <= valid_q[rd_idx];
            rd_tag   <= tags_q[rd_idx];
        end
    end

    assert_reset_clears_valid_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (valid_q == '0));

    assert_fill_sets_valid_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> valid_q[$past(wr_idx)]);

endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store
    import vipt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_en,
    input  idx_t  rd_idx,
    output line_t rd_line,
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  line_t wr_line
);

    line_t lines_q [LINES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            lines_q[wr_idx] <= wr_line;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_line <= '0;
        end else if (rd_en) begin
            rd_line <= lines_q[rd_idx];
        end
    end

    assert_no_read_write_clash_R7: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && wr_en));

endmodule

// File: rtl/vipt_refill.sv
module vipt_refill
    import vipt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  beat_valid,
    input  word_t beat_data,
    output logic  done,
    output line_t line
);

    logic  active_q;
    beat_t cnt_q;
    word_t buf_q [WORDS];

    assign done = active_q && beat_valid && (cnt_q == beat_t'(WORDS - 1));

    // last beat goes straight through; earlier beats come from the buffer
    for (genvar g = 0; g < WORDS; g++) begin : g_line
        if (g == WORDS - 1) begin : g_last
            assign line[g*WORD_W +: WORD_W] = beat_data;
        end else begin : g_held
            assign line[g*WORD_W +: WORD_W] = buf_q[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
        end else if (active_q && beat_valid) begin
            cnt_q <= cnt_q + beat_t'(1);
            if (done) begin
                active_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (active_q && beat_valid) begin
            buf_q[cnt_q] <= beat_data;
        end
    end

    assert_start_arms_refill_R6: assert property (@(posedge clk) disable iff (rst)
        start |=> active_q);

    assert_done_ends_refill_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !active_q);

endmodule

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
    import vipt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req_valid,
    input  addr_t req_vaddr,
    output logic  req_ready,
    input  logic  xlat_valid,
    input  tag_t  xlat_ppn,
    output logic  arr_rd_en,
    output idx_t  arr_rd_idx,
    input  logic  arr_valid,
    input  tag_t  arr_tag,
    input  line_t arr_line,
    output logic  fill_en,
    output idx_t  fill_idx,
    output tag_t  fill_tag,
    output logic  refill_start,
    input  logic  refill_done,
    input  line_t refill_line,
    output logic  mem_req_valid,
    output addr_t mem_req_addr,
    output logic  resp_valid,
    output word_t resp_data
);

    state_e state_q;
    slot_t  slot_q;
    tag_t   ppn_q;
    logic   hit;
    logic   lookup_go;

    assign req_ready    = (state_q == ST_IDLE);
    assign arr_rd_en    = req_ready && req_valid;
    assign arr_rd_idx   = va_slot(req_vaddr).idx;

    // compare once both the array read and translation are in
    assign hit          = arr_valid && (arr_tag == xlat_ppn);
    assign lookup_go    = (state_q == ST_LOOKUP) && xlat_valid;
    assign refill_start = lookup_go && !hit;

    assign fill_en      = (state_q == ST_REFILL) && refill_done;
    assign fill_idx     = slot_q.idx;
    assign fill_tag     = ppn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_IDLE;
            slot_q        <= '0;
            ppn_q         <= '0;
            mem_req_valid <= 1'b0;
            mem_req_addr  <= '0;
            resp_valid    <= 1'b0;
            resp_data     <= '0;
        end else begin
            mem_req_valid <= 1'b0;
            resp_valid    <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        slot_q  <= va_slot(req_vaddr);
                        state_q <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (xlat_valid) begin
                        ppn_q <= xlat_ppn;
                        if (hit) begin
                            resp_valid <= 1'b1;
                            resp_data  <= line_word(arr_line, slot_q.wsel);
                            state_q    <= ST_IDLE;
                        end else begin
                            mem_req_valid <= 1'b1;
                            mem_req_addr  <= line_paddr(xlat_ppn, slot_q.idx);
                            state_q       <= ST_REFILL;
                        end
                    end
                end
                ST_REFILL: begin
                    if (refill_done) begin
                        resp_valid <= 1'b1;
                        resp_data  <= line_word(refill_line, slot_q.wsel);
                        state_q    <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assert_resp_single_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    assert_resp_returns_idle_R8: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> req_ready);

    assert_wait_is_silent_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOOKUP && !xlat_valid) |=> (!resp_valid && !mem_req_valid));

    assert_fetch_single_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);

    assert_fetch_enters_refill_R6: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (state_q == ST_REFILL));

    assert_busy_request_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> $stable(slot_q));

    assert_idle_xlat_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (req_ready && !req_valid && xlat_valid) |=> (!resp_valid && !mem_req_valid));

endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
    import vipt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_vaddr,
    output logic        req_ready,
    input  logic        xlat_valid,
    input  logic [19:0] xlat_ppn,
    output logic        mem_req_valid,
    output logic [31:0] mem_req_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        resp_valid,
    output logic [31:0] resp_data
);

    // the set and line offset must fit in the untranslated bits
    if (IDX_W + OFS_W != PAGE_W) begin : g_geometry_bad
        $error("set bits plus line-offset bits must equal page-offset bits");
    end

    logic  arr_rd_en;
    idx_t  arr_rd_idx;
    logic  arr_valid;
    tag_t  arr_tag;
    line_t arr_line;
    logic  fill_en;
    idx_t  fill_idx;
    tag_t  fill_tag;
    logic  refill_start;
    logic  refill_done;
    line_t refill_line;

    vipt_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_vaddr    (req_vaddr),
        .req_ready    (req_ready),
        .xlat_valid   (xlat_valid),
        .xlat_ppn     (xlat_ppn),
        .arr_rd_en    (arr_rd_en),
        .arr_rd_idx   (arr_rd_idx),
        .arr_valid    (arr_valid),
        .arr_tag      (arr_tag),
        .arr_line     (arr_line),
        .fill_en      (fill_en),
        .fill_idx     (fill_idx),
        .fill_tag     (fill_tag),
        .refill_start (refill_start),
        .refill_done  (refill_done),
        .refill_line  (refill_line),
        .mem_req_valid(mem_req_valid),
        .mem_req_addr (mem_req_addr),
        .resp_valid   (resp_valid),
        .resp_data    (resp_data)
    );

    vipt_tag_store u_tags (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (arr_rd_en),
        .rd_idx  (arr_rd_idx),
        .rd_valid(arr_valid),
        .rd_tag  (arr_tag),
        .wr_en   (fill_en),
        .wr_idx  (fill_idx),
        .wr_tag  (fill_tag)
    );

    vipt_data_store u_data (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (arr_rd_en),
        .rd_idx (arr_rd_idx),
        .rd_line(arr_line),
        .wr_en  (fill_en),
        .wr_idx (fill_idx),
        .wr_line(refill_line)
    );

    vipt_refill u_refill (
        .clk       (clk),
        .rst       (rst),
        .start     (refill_start),
        .beat_valid(mem_rvalid),
        .beat_data (mem_rdata),
        .done      (refill_done),
        .line      (refill_line)
    );

endmodule

// File: tb/vipt_cache_bench.sv
module vipt_cache_bench;
    import vipt_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic        req_ready;
    logic        xlat_valid;
    logic [19:0] xlat_ppn;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        resp_valid;
    logic [31:0] resp_data;

    always #10 clk = ~clk;   // 50 MHz

    vipt_cache u_vipt_cache (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
        .xlat_valid(xlat_valid), .xlat_ppn(xlat_ppn),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .resp_valid(resp_valid), .resp_data(resp_data)
    );

    int          n_tests = 0;
    int          n_fail  = 0;
    int          fills   = 0;
    int          resp_seen = 0;
    logic [31:0] expq [$];
    logic [31:0] exp_fill_addr;
    logic [31:0] fetch_addr;
    logic [19:0] model_tag [256];
    logic        model_vld [256];

    function automatic logic [31:0] memf(input logic [31:0] pa);
        return {pa[31:2], 2'b00} ^ 32'h3C96_A5F0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // monitor: scoreboard pops on every response
    always @(negedge clk) begin
        if (!rst && resp_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R4 response with nothing outstanding", resp_data, 32'h0);
            end else begin
                check(resp_data == expq[0], "R7 returned word", resp_data, expq[0]);
                void'(expq.pop_front());
            end
            resp_seen++;
        end
    end

    // memory model: four beats, with a gap before the third
    initial begin
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                fetch_addr = mem_req_addr;
                fills++;
                check(fetch_addr == exp_fill_addr, "R6 fetch address", fetch_addr, exp_fill_addr);
                repeat (2) @(negedge clk);
                for (int b = 0; b < 4; b++) begin
                    if (b == 2) begin
                        mem_rvalid = 1'b0;
                        @(negedge clk);
                    end
                    mem_rvalid = 1'b1;
                    mem_rdata  = memf(fetch_addr + 32'(4 * b));
                    @(negedge clk);
                end
                mem_rvalid = 1'b0;
            end
        end
    end

    // one access: request, translation after dly cycles, wait for the answer
    task automatic access(input logic [31:0] va, input logic [19:0] ppn, input int dly,
                          input bit poke, input string tag_req);
        logic [7:0] idx;
        logic [1:0] ws;
        bit         miss;
        bit         quiet;
        int         f0;
        int         r0;
        idx   = va[11:4];
        ws    = va[3:2];
        miss  = !model_vld[idx] || (model_tag[idx] != ppn);
        f0    = fills;
        r0    = resp_seen;
        quiet = 1'b1;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 1; i < dly; i++) begin
            if (resp_valid || mem_req_valid) quiet = 1'b0;
            @(negedge clk);
        end
        if (dly > 1) check(quiet, "R5 silent while translation pending", 32'(quiet), 32'h1);
        xlat_valid    = 1'b1;
        xlat_ppn      = ppn;
        exp_fill_addr = {ppn, idx, 4'b0000};
        expq.push_back(memf({ppn, idx, ws, 2'b00}));
        @(negedge clk);
        xlat_valid = 1'b0;
        if (!miss)
            check(resp_valid, "R4 hit answer one cycle after translation", 32'(resp_valid), 32'h1);
        else
            check(mem_req_valid && !resp_valid, "R6 fetch pulse after translation",
                  32'(mem_req_valid), 32'h1);
        if (poke) begin
            for (int i = 0; i < 3; i++) begin
                req_valid = 1'b1;
                req_vaddr = va ^ 32'h0000_0FF0;
                check(!req_ready, "R8 not ready while busy", 32'(req_ready), 32'h0);
                @(negedge clk);
            end
            req_valid = 1'b0;
        end
        while (resp_seen == r0) @(negedge clk);
        check((fills - f0) == int'(miss), tag_req, 32'(fills - f0), 32'(miss));
        model_vld[idx] = 1'b1;
        model_tag[idx] = ppn;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R5 watchdog: run did not complete", 32'h0, 32'h1);
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            model_vld[i] = 1'b0;
            model_tag[i] = '0;
        end
        rst        = 1'b1;
        req_valid  = 1'b0;
        req_vaddr  = '0;
        xlat_valid = 1'b0;
        xlat_ppn   = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!resp_valid && !mem_req_valid, "R1 outputs idle after reset",
              {30'h0, resp_valid, mem_req_valid}, 32'h0);
        check(req_ready, "R1 ready after reset", 32'(req_ready), 32'h1);

        // cold miss, then every word of the line hits
        access(32'h0000_1234, 20'h12345, 1, 1'b0, "R1 cold access misses");
        access(32'h0000_1230, 20'h12345, 1, 1'b0, "R7 word 0 hits after fill");
        access(32'h0000_1238, 20'h12345, 1, 1'b0, "R7 word 2 hits after fill");
        access(32'h0000_123C, 20'h12345, 2, 1'b0, "R7 word 3 hits after fill");
        // upper virtual bits differ, same physical page
        access(32'hABCD_E234, 20'h12345, 1, 1'b0, "R2 upper virtual bits ignored");
        access(32'h7777_7230, 20'h12345, 3, 1'b0, "R2 upper virtual bits ignored");
        // same set, different physical page
        access(32'h0000_1234, 20'h54321, 1, 1'b0, "R3 tag mismatch misses");
        access(32'h0000_1234, 20'h12345, 1, 1'b0, "R10 evicted page misses again");
        // late translation
        access(32'h0000_1238, 20'h12345, 6, 1'b0, "R5 late translation still hits");

        // translation valid while idle
        xlat_valid = 1'b1;
        xlat_ppn   = 20'h0BEEF;
        @(negedge clk);
        @(negedge clk);
        xlat_valid = 1'b0;
        check(!resp_valid && !mem_req_valid, "R9 idle translation ignored",
              {30'h0, resp_valid, mem_req_valid}, 32'h0);
        access(32'h0000_1230, 20'h12345, 1, 1'b0, "R9 line kept after idle translation");

        // requests while busy
        access(32'h0000_5A48, 20'h00777, 1, 1'b1, "R8 busy miss fetches once");
        check(req_ready && !mem_req_valid, "R8 busy request not taken later",
              {30'h0, req_ready, mem_req_valid}, 32'h2);
        check(expq.size() == 0, "R8 no extra response", 32'(expq.size()), 32'h0);

        // mixed stream with set conflicts
        for (int i = 0; i < 40; i++) begin
            logic [31:0] va;
            logic [19:0] pp;
            va = {20'(i * 32'h9E37), 4'(i % 3), 4'(i % 5), 2'(i), 2'b00};
            pp = 20'h40000 + 20'(i % 3);
            access(va, pp, 1 + (i % 3), 1'b0, "R3 hit or miss per stored tag");
        end

        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R4 all responses delivered", 32'(expq.size()), 32'h0);
        summary();
        $finish;
    end

endmodule